// File: doc/BRIEF.md
# One-Shot Tick-Count Interrupt Timer

This block paces a slow transmission, such as the bit stream of an infrared remote control. Software writes a 4-bit interval setting. The block then counts falling edges of a slow reference tick and sets an interrupt flag on the edge that completes the selected number of periods. The next bit can then be scheduled from the interrupt handler, and no processor time goes into polling.

Every write arms exactly one count. The stored setting stays visible on an output, but it does not re-arm by itself, so software writes again for each interrupt, even when the value is the same. The flag is set whether or not the interrupt is masked. The mask only gates the registered request output. Reading the flag clears it. When the enclosing circuit is disabled, the setting returns to its longest value and the timer stays idle until the next write.

Top module: `tick_oneshot_timer`

## Requirements
- R1: A written setting v (0 to 15) arms a count. The flag sets on the (v+1)-th tick falling edge after the write: 0 gives one period and 15 gives sixteen. `setting_o` shows the written value from the clock edge after the write.
- R2: Only a high-to-low transition of `tick_i`, sampled at the system clock, advances the count. A low level held over many clocks counts once, and a rising edge counts nothing.
- R3: The flag stays 0 after v falling edges. It becomes 1 at the clock edge on which the completing falling edge is detected.
- R4: The flag sets on completion whatever the value of `mask_i`. `irq_o` is a registered copy of flag AND NOT mask, where `mask_i` = 1 blocks the request.
- R5: A one-cycle pulse on `flag_rd_i` clears `flag_o` and `irq_o` at the next clock edge.
- R6: After a completion, further tick edges never set the flag again until a new write. `setting_o` keeps the last written value.
- R7: At reset, and one clock after `enable_i` goes low, `setting_o` reads 15 and any running count is dropped. Writes are ignored while the block is disabled. After re-enable, no count runs until a write.
- R8: A write while a count is running restarts the count from zero with the new setting.
- R9: If a flag read and a count completion fall in the same clock, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Circuit enable; low forces the idle default |
| wr_i | input | 1 | One-cycle write strobe for the setting |
| wr_data_i | input | 4 | Interval setting v; v+1 tick periods |
| flag_rd_i | input | 1 | Flag read strobe; clears the flag |
| mask_i | input | 1 | 1 blocks the interrupt request |
| tick_i | input | 1 | Slow reference tick, synchronous to clk_i |
| setting_o | output | 4 | Stored interval setting |
| flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Registered, masked interrupt request |

## Verification
The assertions assume that `tick_i` is already synchronous to the system clock and stays at each level for at least one clock. That way every transition is seen once and the edge detector never meets a glitch. They also assume that the write and read strobes are single-cycle pulses. The bench drives every input on the falling clock edge and holds each tick level for at least one full clock. It raises write and read strobes for exactly one cycle, so the stimulus stays within what the properties take for granted.

// File: rtl/tot_pkg.sv
package tot_pkg;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_RUN  = 1'b1
    } arm_state_e;

endpackage

// File: rtl/tot_tick_edge.sv
module tot_tick_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic fall_o
);

    typedef struct packed {
        logic tick;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = tick_i;
        fall_o   = s_q.tick & ~tick_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R2: a falling edge indication lasts exactly one clock
    p_single_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tot_arm_counter.sv
module tot_arm_counter
    import tot_pkg::*;
#(
    parameter int unsigned SET_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             wr_i,
    input  logic [SET_W-1:0] wr_data_i,
    input  logic             fall_i,
    output logic [SET_W-1:0] setting_o,
    output logic             done_o
);

    localparam logic [SET_W-1:0] SET_DEFAULT = {SET_W{1'b1}};
    localparam logic [SET_W-1:0] CNT_ONE     = SET_W'(1);

    typedef struct packed {
        logic [SET_W-1:0] setting;
        logic [SET_W-1:0] cnt;
        arm_state_e       st;
    } arm_state_t;

    arm_state_t s_d, s_q;
    logic       done_d;

    always_comb begin
        s_d    = s_q;
        done_d = 1'b0;
        if (!enable_i) begin
            s_d.setting = SET_DEFAULT;
            s_d.cnt     = '0;
            s_d.st      = ARM_IDLE;
        end else if (wr_i) begin
            s_d.setting = wr_data_i;
            s_d.cnt     = '0;
            s_d.st      = ARM_RUN;
        end else if (s_q.st == ARM_RUN && fall_i) begin
            if (s_q.cnt == s_q.setting) begin
                done_d  = 1'b1;
                s_d.cnt = '0;
                s_d.st  = ARM_IDLE;
            end else begin
                s_d.cnt = s_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.setting <= SET_DEFAULT;
            s_q.cnt     <= '0;
            s_q.st      <= ARM_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign setting_o = s_q.setting;
    assign done_o    = done_d;

    // R1: a running count never passes its setting
    p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ARM_RUN) |-> (s_q.cnt <= s_q.setting));

    // R6: a completion disarms the counter
    p_disarm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (s_q.st == ARM_IDLE));

    // R7: disabling returns to the idle default
    p_disable_default_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (setting_o == SET_DEFAULT && s_q.st == ARM_IDLE));

    // R8: a write restarts from zero
    p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && wr_i) |=> (s_q.cnt == '0 && s_q.st == ARM_RUN));

endmodule

// File: rtl/tot_flag_irq.sv
module tot_flag_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic done_i,
    input  logic flag_rd_i,
    input  logic mask_i,
    output logic flag_o,
    output logic irq_o
);

    typedef struct packed {
        logic flag;
        logic irq;
    } flag_state_t;

    flag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done_i)         s_d.flag = 1'b1;
        else if (flag_rd_i) s_d.flag = 1'b0;
        s_d.irq = s_d.flag & ~mask_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign flag_o = s_q.flag;
    assign irq_o  = s_q.irq;

    // R4: completion sets the flag regardless of the mask
    p_done_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> flag_o);

    // R4: a request is never raised without the flag
    p_irq_needs_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> flag_o);

    // R4: a masked cycle yields no request
    p_mask_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i |=> !irq_o);

    // R5: a read without completion clears
    p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_rd_i && !done_i) |=> !flag_o);

    // R9: completion wins over a read
    p_done_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_rd_i && done_i) |=> flag_o);

endmodule

// File: rtl/tick_oneshot_timer.sv
module tick_oneshot_timer #(
    parameter int unsigned SET_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             wr_i,
    input  logic [SET_W-1:0] wr_data_i,
    input  logic             flag_rd_i,
    input  logic             mask_i,
    input  logic             tick_i,
    output logic [SET_W-1:0] setting_o,
    output logic             flag_o,
    output logic             irq_o
);

    logic fall;
    logic done;

    tot_tick_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .fall_o (fall)
    );

    tot_arm_counter #(.SET_W(SET_W)) i_arm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (enable_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .fall_i    (fall),
        .setting_o (setting_o),
        .done_o    (done)
    );

    tot_flag_irq i_flag (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .done_i    (done),
        .flag_rd_i (flag_rd_i),
        .mask_i    (mask_i),
        .flag_o    (flag_o),
        .irq_o     (irq_o)
    );

    // R2: completion happens only on a detected falling edge
    p_done_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |-> fall);

    // R7: no completion while disabled
    p_no_done_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !done);

endmodule

// File: tb/test_tick_oneshot_timer.sv
module test_tick_oneshot_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] wdata = '0;
    logic       rd = 1'b0;
    logic       mask = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] setting;
    logic       flag;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    tick_oneshot_timer i_tick_oneshot_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .enable_i  (en),
        .wr_i      (wr),
        .wr_data_i (wdata),
        .flag_rd_i (rd),
        .mask_i    (mask),
        .tick_i    (tick),
        .setting_o (setting),
        .flag_o    (flag),
        .irq_o     (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(input logic [3:0] v);
        wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic tick_fall();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_flag();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        check(setting == 4'd15, "R7 reset setting", setting, 15);
        check(flag == 1'b0, "R7 reset flag", flag, 0);
        check(irq == 1'b0, "R7 reset irq", irq, 0);
    endtask

    task automatic t_interval(input int v);
        write(v[3:0]);
        check(setting == v[3:0], "R1 setting readback", setting, v);
        for (int i = 0; i < v; i++) tick_fall();
        check(flag == 1'b0, "R3 flag early", flag, 0);
        tick_fall();
        check(flag == 1'b1, "R1 flag after v+1 edges", flag, 1);
        check(irq == 1'b1, "R4 irq unmasked", irq, 1);
        read_flag();
        check(flag == 1'b0, "R5 read clears flag", flag, 0);
        check(irq == 1'b0, "R5 read clears irq", irq, 0);
    endtask

    task automatic t_edges_only();
        write(4'd1);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (10) @(negedge clk);
        check(flag == 1'b0, "R2 long low counts once", flag, 0);
        tick = 1'b1;
        repeat (5) @(negedge clk);
        check(flag == 1'b0, "R2 rising edge not counted", flag, 0);
        tick = 1'b0;
        @(negedge clk);
        check(flag == 1'b1, "R2 second fall completes", flag, 1);
        read_flag();
    endtask

    task automatic t_mask();
        mask = 1'b1;
        write(4'd2);
        repeat (3) tick_fall();
        check(flag == 1'b1, "R4 flag sets while masked", flag, 1);
        check(irq == 1'b0, "R4 masked irq low", irq, 0);
        mask = 1'b0;
        @(negedge clk);
        check(irq == 1'b1, "R4 unmask raises irq", irq, 1);
        read_flag();
    endtask

    task automatic t_oneshot();
        write(4'd0);
        tick_fall();
        check(flag == 1'b1, "R6 first shot", flag, 1);
        read_flag();
        repeat (20) tick_fall();
        check(flag == 1'b0, "R6 no re-arm", flag, 0);
        check(setting == 4'd0, "R6 setting kept", setting, 0);
        write(4'd0);
        tick_fall();
        check(flag == 1'b1, "R6 rewrite same value", flag, 1);
        read_flag();
    endtask

    task automatic t_disable();
        write(4'd3);
        tick_fall();
        en = 1'b0;
        @(negedge clk);
        check(setting == 4'd15, "R7 disable default", setting, 15);
        write(4'd2);
        check(setting == 4'd15, "R7 write ignored when disabled", setting, 15);
        repeat (5) tick_fall();
        check(flag == 1'b0, "R7 no count while disabled", flag, 0);
        en = 1'b1;
        @(negedge clk);
        repeat (20) tick_fall();
        check(flag == 1'b0, "R7 idle after re-enable", flag, 0);
    endtask

    task automatic t_restart();
        write(4'd5);
        repeat (3) tick_fall();
        write(4'd1);
        tick_fall();
        check(flag == 1'b0, "R8 restart from zero", flag, 0);
        tick_fall();
        check(flag == 1'b1, "R8 new setting completes", flag, 1);
        read_flag();
    endtask

    task automatic t_collision();
        write(4'd0);
        tick_fall();
        write(4'd0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check(flag == 1'b1, "R9 completion beats read", flag, 1);
        read_flag();
        check(flag == 1'b0, "R9 later read clears", flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        en = 1'b1;
        @(negedge clk);
        t_interval(0);
        t_interval(4);
        t_interval(15);
        t_edges_only();
        t_mask();
        t_oneshot();
        t_disable();
        t_restart();
        t_collision();
        if (!done_run) begin
            done_run = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done_run) begin
            done_run = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule